// File: doc/BRIEF.md
# Free-running-clock SPI master

This block is the transmit and receive engine of an SPI master whose serial clock comes from a bus-clock divider that never restarts. The divider runs whenever the block is both enabled and set to master mode. A 2-bit rate field picks a division of 2, 8, 32 or 128 bus cycles per bit. A write strobe queues one byte. The byte then waits for the divider's next bit boundary before any shifting starts. Because of this, the delay from the write to the first serial clock edge depends on where the write falls against the divider, and it varies by up to one bit time.

Once a transfer starts, the block makes eight serial clock cycles. The clock polarity and phase inputs set the idle level and choose which edge drives and which edge samples. Data goes out and comes in most significant bit first. The received byte is presented on a parallel output, and a completion flag is set when the last bit has been sampled. The next accepted write clears that flag.

Top module: `spim_top`

## Requirements
- R1: The bit-rate divider counts only while `spi_en` and `master` are both 1. Otherwise it is held at zero. While either input is 0, a write is not accepted, `sck` stays at its idle level, and no queued byte is remembered for later.
- R2: `rate_sel` values 0, 1, 2 and 3 select 2, 8, 32 and 128 bus cycles per bit. Within a transfer, consecutive `sck` edges are exactly half that many bus cycles apart.
- R3: The divider runs freely and is not reset by a write. A transfer begins at the first bit boundary after the write, which is 1 to D cycles after the write cycle, where D is the selected division. The first `sck` edge follows D/2 cycles after that. Counted from the write cycle, the first `sck` edge therefore comes D/2+1 to D+D/2 cycles later.
- R4: `sck` rests at the level of `cpol` when no transfer is running. Every transfer makes exactly 16 edges (8 clock cycles) and then returns to the idle level.
- R5: The written byte appears on `mosi` most significant bit first.
- R6: With `cpha` = 0, bit 7 is on `mosi` from the start of the transfer, before the first edge. The slave samples on the first edge of each cycle, and `mosi` changes on the second edge.
- R7: With `cpha` = 1, the first edge of a transfer moves `sck` from the idle level to the active level. `mosi` changes on the first edge of each cycle, and the block samples `miso` on the second edge.
- R8: `miso` is assembled most significant bit first. At the eighth sample the byte is loaded into `rx_data` and `xfer_done` is set to 1.
- R9: A write that is accepted clears `xfer_done` in the following cycle.
- R10: A write that arrives while a byte is queued or being shifted is ignored. The byte on `mosi` is not altered, no further transfer follows, and `xfer_done` is not cleared by that write.
- R11: While reset is asserted, `mosi` is 0, `rx_data` is 0, `xfer_done` is 0 and `sck` equals `cpol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_en | input | 1 | Block enable |
| master | input | 1 | Master mode select |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | Clock phase select |
| rate_sel | input | 2 | Bit-rate select: 0 selects /2, 1 selects /8, 2 selects /32, 3 selects /128 |
| wr_stb | input | 1 | One-cycle strobe that writes the transmit byte |
| wr_data | input | 8 | Byte to transmit |
| miso | input | 1 | Serial data from the slave |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| rx_data | output | 8 | Last received byte |
| xfer_done | output | 1 | Transfer-complete flag |

## Verification
The assertions check several rules on every cycle. The divider is held at zero while the block is disabled. `sck` sits at `cpol` whenever nothing is shifting, and it moves only on a divider half-tick. A queued byte never waits longer than one bit time. An accepted write always clears the flag, and the held byte stays unchanged while a write is refused. Other properties can only be shown by the bench scenarios, which act as a slave on the wire. These are the bit order on `mosi`, the byte assembled from `miso`, the edge that drives and the edge that samples in each phase mode, and the exact spacing of the 16 edges. They also include whether the start latency stays inside the one-bit window as the write moves against the free-running divider, and the absence of any extra transfer after a refused write.

// File: rtl/spim_pkg.sv
`timescale 1ns/1ps
package spim_pkg;
  localparam int unsigned MAX_DIV = 128;

  // bus cycles per bit for a given rate code: 2, 8, 32, 128
  function automatic int unsigned div_of(input logic [1:0] sel);
    int unsigned base;
    base = 2;
    return base << (2 * int'(sel));
  endfunction
endpackage

// File: rtl/spim_rate_div.sv
`timescale 1ns/1ps
module spim_rate_div
  import spim_pkg::*;
#(
  parameter int CNT_W = $clog2(MAX_DIV)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] rate_sel,
  output logic [CNT_W-1:0] cnt,
  output logic       half_tick,
  output logic       bit_tick
);
  logic [CNT_W-1:0] cnt_q, cnt_d, last_v, half_v;

  always_comb begin
    last_v    = CNT_W'(div_of(rate_sel) - 1);
    half_v    = CNT_W'(div_of(rate_sel) / 2 - 1);
    bit_tick  = run && (cnt_q == last_v);
    half_tick = run && ((cnt_q == last_v) || (cnt_q == half_v));
    if (!run)                cnt_d = '0;
    else if (cnt_q >= last_v) cnt_d = '0;
    else                     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/spim_ctrl.sv
`timescale 1ns/1ps
module spim_ctrl #(
  parameter int DATA_W = 8,
  localparam int EDGES = 2 * DATA_W,
  localparam int EC_W  = $clog2(EDGES)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic cpha,
  input  logic wr_stb,
  input  logic half_tick,
  input  logic bit_tick,
  output logic busy,
  output logic pend,
  output logic sck_act,
  output logic done,
  output logic accept,
  output logic start,
  output logic drive,
  output logic sample,
  output logic last_sample
);
  logic busy_q, busy_d, pend_q, pend_d, act_q, act_d, done_q, done_d;
  logic [EC_W-1:0] ec_q, ec_d;
  logic edge_ev, lead, last_edge;

  always_comb begin
    accept    = wr_stb && run && !busy_q && !pend_q;
    start     = run && pend_q && bit_tick;
    edge_ev   = run && busy_q && half_tick;
    lead      = !ec_q[0];
    last_edge = (ec_q == EC_W'(EDGES - 1));
    drive     = edge_ev && (cpha ? lead : (!lead && !last_edge));
    sample    = edge_ev && (cpha ? !lead : lead);
    last_sample = sample &&
                  (ec_q == (cpha ? EC_W'(EDGES - 1) : EC_W'(EDGES - 2)));

    pend_d = pend_q;
    busy_d = busy_q;
    act_d  = act_q;
    ec_d   = ec_q;
    done_d = done_q;
    if (!run) begin
      pend_d = 1'b0;
      busy_d = 1'b0;
      act_d  = 1'b0;
    end else begin
      if (accept)      pend_d = 1'b1;
      else if (start)  pend_d = 1'b0;
      if (start) begin
        busy_d = 1'b1;
        ec_d   = '0;
      end else if (edge_ev) begin
        act_d = !act_q;
        ec_d  = ec_q + 1'b1;
        if (last_edge) busy_d = 1'b0;
      end
    end
    if (accept)           done_d = 1'b0;
    else if (last_sample) done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      busy_q <= 1'b0;
      act_q  <= 1'b0;
      ec_q   <= '0;
      done_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      busy_q <= busy_d;
      act_q  <= act_d;
      ec_q   <= ec_d;
      done_q <= done_d;
    end
  end

  assign busy    = busy_q;
  assign pend    = pend_q;
  assign sck_act = act_q;
  assign done    = done_q;
endmodule

// File: rtl/spim_shifter.sv
`timescale 1ns/1ps
module spim_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpha,
  input  logic              accept,
  input  logic              start,
  input  logic              drive,
  input  logic              sample,
  input  logic              last_sample,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] held,
  output logic [DATA_W-1:0] rx_data
);
  logic [DATA_W-1:0] hold_q, tx_q, tx_d, rs_q, rs_d, rx_q, rx_d;
  logic mosi_q, mosi_d, tx_en;

  always_comb begin
    tx_en  = start || drive;
    tx_d   = tx_q;
    mosi_d = mosi_q;
    if (start) begin
      if (cpha) begin
        tx_d = hold_q;
      end else begin
        mosi_d = hold_q[DATA_W-1];
        tx_d   = {hold_q[DATA_W-2:0], 1'b0};
      end
    end else if (drive) begin
      mosi_d = tx_q[DATA_W-1];
      tx_d   = {tx_q[DATA_W-2:0], 1'b0};
    end
    rs_d = {rs_q[DATA_W-2:0], miso};
    rx_d = rs_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      tx_q   <= '0;
      mosi_q <= 1'b0;
      rs_q   <= '0;
      rx_q   <= '0;
    end else begin
      if (accept)      hold_q <= wr_data;
      if (tx_en)       tx_q   <= tx_d;
      if (tx_en)       mosi_q <= mosi_d;
      if (sample)      rs_q   <= rs_d;
      if (last_sample) rx_q   <= rx_d;
    end
  end

  assign mosi    = mosi_q;
  assign held    = hold_q;
  assign rx_data = rx_q;
endmodule

// File: rtl/spim_top.sv
`timescale 1ns/1ps
module spim_top
  import spim_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(MAX_DIV)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_en,
  input  logic              master,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [1:0]        rate_sel,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_data,
  output logic              xfer_done
);
  logic run, half_tick, bit_tick;
  logic busy, pend, sck_act, accept, start, drive, sample, last_sample;
  logic [CNT_W-1:0]  div_cnt;
  logic [DATA_W-1:0] held;

  assign run = spi_en && master;

  spim_rate_div #(.CNT_W(CNT_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .rate_sel(rate_sel),
    .cnt(div_cnt), .half_tick(half_tick), .bit_tick(bit_tick)
  );

  spim_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .run(run), .cpha(cpha), .wr_stb(wr_stb),
    .half_tick(half_tick), .bit_tick(bit_tick),
    .busy(busy), .pend(pend), .sck_act(sck_act), .done(xfer_done),
    .accept(accept), .start(start), .drive(drive), .sample(sample),
    .last_sample(last_sample)
  );

  spim_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .cpha(cpha), .accept(accept), .start(start),
    .drive(drive), .sample(sample), .last_sample(last_sample),
    .wr_data(wr_data), .miso(miso), .mosi(mosi), .held(held),
    .rx_data(rx_data)
  );

  assign sck = cpol ^ sck_act;
endmodule

// File: rtl/spim_checker.sv
`timescale 1ns/1ps
module spim_checker
  import spim_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              spi_en,
  input logic              master,
  input logic              cpol,
  input logic [1:0]        rate_sel,
  input logic              wr_stb,
  input logic              sck,
  input logic              xfer_done,
  input logic              busy,
  input logic              pend,
  input logic              half_tick,
  input logic [CNT_W-1:0]  div_cnt,
  input logic [DATA_W-1:0] held
);
  logic [7:0] wait_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    wait_q <= '0;
    else if (pend) wait_q <= wait_q + 1'b1;
    else           wait_q <= '0;
  end

  assert_div_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(spi_en && master) |=> (div_cnt == '0));

  assert_sck_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sck) && $stable(cpol)) |-> $past(half_tick));

  assert_start_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> (int'(wait_q) < int'(div_of(rate_sel))));

  assert_sck_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> (sck == cpol));

  assert_done_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && spi_en && master && !busy && !pend) |=> !xfer_done);

  assert_ignore_wr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && (busy || pend)) |=> $stable(held));
endmodule

bind spim_top spim_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_spim_checker (
  .clk(clk), .rst_n(rst_n), .spi_en(spi_en), .master(master), .cpol(cpol),
  .rate_sel(rate_sel), .wr_stb(wr_stb), .sck(sck), .xfer_done(xfer_done),
  .busy(busy), .pend(pend), .half_tick(half_tick), .div_cnt(div_cnt),
  .held(held)
);

// File: tb/test_spim_top.sv
`timescale 1ns/1ps
module test_spim_top;
  logic       clk, rst_n, spi_en, master, cpol, cpha, wr_stb, miso;
  logic [1:0] rate_sel;
  logic [7:0] wr_data, rx_data;
  logic       sck, mosi, xfer_done;
  int errors = 0;
  int checks = 0;

  spim_top i_spim_top (
    .clk(clk), .rst_n(rst_n), .spi_en(spi_en), .master(master), .cpol(cpol),
    .cpha(cpha), .rate_sel(rate_sel), .wr_stb(wr_stb), .wr_data(wr_data),
    .miso(miso), .sck(sck), .mosi(mosi), .rx_data(rx_data),
    .xfer_done(xfer_done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // fields: rate[23:22] cpol[21] cpha[20] tx[19:12] slave[11:4] gap[3:0]
  localparam logic [23:0] VEC [8] = '{
    {2'd0, 1'b0, 1'b0, 8'hA5, 8'h3C, 4'd0},
    {2'd0, 1'b1, 1'b1, 8'h81, 8'h7E, 4'd1},
    {2'd1, 1'b0, 1'b1, 8'h5A, 8'hC3, 4'd3},
    {2'd1, 1'b1, 1'b0, 8'hFF, 8'h00, 4'd6},
    {2'd2, 1'b0, 1'b0, 8'h01, 8'h80, 4'd11},
    {2'd2, 1'b1, 1'b1, 8'h96, 8'h69, 4'd2},
    {2'd3, 1'b0, 1'b1, 8'h00, 8'hFF, 4'd9},
    {2'd3, 1'b1, 1'b0, 8'hE7, 8'h18, 4'd15}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_xfer(input logic [1:0] rt, input logic pol, input logic pha,
                         input logic [7:0] tx, input logic [7:0] sb,
                         input int gap, input bit inj);
    int d, h, edges, last, lat, idx;
    bit spacing_ok, injected, lead;
    logic prev;
    logic [7:0] cap;
    d = 2 << (2 * int'(rt));
    h = d / 2;
    @(negedge clk);
    rate_sel = rt; cpol = pol; cpha = pha; miso = sb[7];
    repeat (gap + 2) @(negedge clk);
    wr_stb = 1'b1; wr_data = tx;
    @(negedge clk);
    wr_stb = 1'b0;
    chk(xfer_done == 1'b0, "R9", "flag after accepted write", xfer_done, 0);
    edges = 0; last = 0; lat = 0; idx = 0; cap = '0;
    spacing_ok = 1'b1; injected = 1'b0; prev = sck;
    for (int n = 0; n < 40 * d && edges < 16; n++) begin
      if (wr_stb) wr_stb = 1'b0;
      else if (inj && !injected && edges == 5) begin
        wr_stb = 1'b1; wr_data = ~tx; injected = 1'b1;
      end
      if (sck !== prev) begin
        edges++;
        if (edges == 1) lat = n;
        else if (n - last != h) spacing_ok = 1'b0;
        last = n;
        lead = (sck != pol);
        if (edges == 1)
          chk(lead, pha ? "R7" : "R4", "first edge leaves idle level", int'(lead), 1);
        if (lead == !pha) cap = {cap[6:0], mosi};
        else if (pha) begin
          miso = sb[7 - idx]; idx++;
        end else begin
          idx++;
          if (idx < 8) miso = sb[7 - idx];
        end
        prev = sck;
      end
      @(negedge clk);
    end
    wr_stb = 1'b0;
    repeat (2) @(negedge clk);
    chk(edges == 16, "R4", "edge count", edges, 16);
    chk(sck == pol, "R4", "sck back at idle", sck, pol);
    chk(spacing_ok, "R2", "edge spacing in half bit times", int'(spacing_ok), 1);
    chk(lat >= h + 1 && lat <= d + h, "R3", "start latency window", lat, d);
    chk(cap == tx, pha ? "R7" : "R6", "byte seen on mosi (R5 msb first)", cap, tx);
    chk(rx_data == sb, "R8", "received byte", rx_data, sb);
    chk(xfer_done == 1'b1, "R8", "complete flag", xfer_done, 1);
    if (inj) begin
      bit quiet;
      quiet = 1'b1;
      for (int n = 0; n < 2 * d + 8; n++) begin
        if (sck != pol) quiet = 1'b0;
        @(negedge clk);
      end
      chk(quiet, "R10", "no transfer from refused write", int'(quiet), 1);
      chk(xfer_done == 1'b1, "R10", "flag kept after refused write", xfer_done, 1);
    end
  endtask

  initial begin
    rst_n = 1'b0; spi_en = 1'b1; master = 1'b1; cpol = 1'b0; cpha = 1'b0;
    rate_sel = 2'd0; wr_stb = 1'b0; wr_data = '0; miso = 1'b0;
    repeat (3) @(negedge clk);
    chk(mosi == 1'b0, "R11", "mosi in reset", mosi, 0);
    chk(rx_data == 8'h00, "R11", "rx_data in reset", rx_data, 0);
    chk(xfer_done == 1'b0, "R11", "flag in reset", xfer_done, 0);
    chk(sck == 1'b0, "R11", "sck in reset", sck, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      logic [23:0] v;
      v = VEC[i];
      do_xfer(v[23:22], v[21], v[20], v[19:12], v[11:4], int'(v[3:0]), 1'b0);
    end

    // refused write in the middle of a transfer, both phase modes
    do_xfer(2'd1, 1'b0, 1'b0, 8'hC6, 8'h5B, 2, 1'b1);
    do_xfer(2'd2, 1'b1, 1'b1, 8'h3A, 8'hD4, 5, 1'b1);

    // disabled: write is refused, nothing is queued (R1)
    begin
      bit quiet;
      logic m0;
      @(negedge clk);
      rate_sel = 2'd1; cpol = 1'b0; cpha = 1'b0; spi_en = 1'b0;
      m0 = mosi;
      wr_stb = 1'b1; wr_data = 8'h0F;
      @(negedge clk);
      wr_stb = 1'b0;
      quiet = 1'b1;
      for (int n = 0; n < 100; n++) begin
        if (sck != 1'b0 || mosi != m0) quiet = 1'b0;
        @(negedge clk);
      end
      chk(quiet, "R1", "no activity while disabled", int'(quiet), 1);
      chk(xfer_done == 1'b1, "R1", "flag untouched by refused write", xfer_done, 1);
      spi_en = 1'b1;
      for (int n = 0; n < 100; n++) begin
        if (sck != 1'b0) quiet = 1'b0;
        @(negedge clk);
      end
      chk(quiet, "R1", "no queued byte after enable", int'(quiet), 1);
      master = 1'b0;
      wr_stb = 1'b1; wr_data = 8'hF0;
      @(negedge clk);
      wr_stb = 1'b0;
      repeat (20) @(negedge clk);
      master = 1'b1;
      for (int n = 0; n < 100; n++) begin
        if (sck != 1'b0) quiet = 1'b0;
        @(negedge clk);
      end
      chk(quiet, "R1", "no transfer when not master", int'(quiet), 1);
    end

    // a normal transfer still works afterwards
    do_xfer(2'd0, 1'b0, 1'b1, 8'h4D, 8'hB2, 0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule